// File: doc/BRIEF.md
# Power-Management Event Register Block with SCI/SMI Generation

This block is the event side of a chipset power-management function. Software reaches it through a 64-byte I/O window whose base address and on/off switch sit in a small byte-addressed configuration space. Inside the window are four registers: event status, event enable, control and a free-running timer. Hardware event sources (power button, RTC alarm, global-lock release and the timer's own rollover) latch bits in the status register. Software clears those bits by writing ones.

A level-sensitive system control interrupt (SCI) is driven high while any of the four interrupting event classes is both latched and enabled. It is also driven high while an externally supplied hotplug event is both pending and enabled. A separate command-byte port switches ACPI mode on or off by setting or clearing the SCI-enable bit of the control register. When armed by a configuration bit, that port also fires a one-cycle system management interrupt (SMI) pulse.

Top module: `pm_sci_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low), the status, enable, control and timer registers are zero and sci_o and smi_o are low. Configuration bytes 0x58..0x5B and 0x80 read zero, and configuration byte 0x40 reads 0x01.
- R2: The I/O window is decoded only while bit 0 of configuration byte 0x80 is 1. Its base is the 16-bit value {byte 0x41, byte 0x40} ANDed with 0xFFC0. Bit 0 of byte 0x40 always reads 1. An I/O access outside the decoded window returns io_rdata = 0, and a write there changes no register.
- R3: Window offsets are 0x00 = status, 0x02 = enable, 0x04 = control and 0x08 = timer. Enable and control store all 16 written bits. Any other offset reads 0, and a write to it changes no register.
- R4: A one-cycle high on ev_pwrbtn, ev_rtc or ev_glbl sets status bit 8, 10 or 5 respectively. The bit stays set until software clears it.
- R5: Status bits are write-one-to-clear: a status write clears exactly the bits written as 1. An event arriving in the same cycle as the clear of its bit leaves the bit set.
- R6: sci_o is a registered level, updated on the clock edge after the registers change. It is 1 exactly when (status AND enable) has any of bits 0, 5, 8 or 10 set, or when hp_sts and hp_en are both 1.
- R7: The timer is a TMR_W-bit counter that advances by one every clock. It reads zero-extended at offset 0x08. When it wraps from all-ones to zero it sets status bit 0.
- R8: A command-port write of 0xF1 sets control bit 0, a write of 0xF0 clears it, and any other value leaves it unchanged. The command wins over an I/O write to control bit 0 in the same cycle.
- R9: On every command-port write, smi_o pulses high for exactly one cycle on the next clock edge, but only while bit 1 of configuration byte 0x5B is set.
- R10: Enable bits outside positions 0, 5, 8 and 10 never cause sci_o to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | DATA_W | I/O read data (combinational, zero outside the window) |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_data | input | 8 | Command byte |
| ev_pwrbtn | input | 1 | Power-button event pulse |
| ev_rtc | input | 1 | RTC alarm event pulse |
| ev_glbl | input | 1 | Global-lock release event pulse |
| hp_sts | input | 1 | External hotplug event pending |
| hp_en | input | 1 | External hotplug event enabled |
| sci_o | output | 1 | System control interrupt level |
| smi_o | output | 1 | System management interrupt pulse |

## Verification
The bench attacks the address decode from three sides. It writes while the window is switched off, writes just below a base that has low bits set in configuration, and writes to an unassigned offset. A decoder that ignored the switch, the 0xFFC0 mask or the offset list would corrupt the enable register or return nonzero data. It drives a status clear and the matching event into the same cycle, where a clear-wins design would lose the event. It also drives a command byte and an I/O control write together, where the wrong priority drops the mode change. A vector table covers each interrupt class, hotplug status and enable in all combinations, and enable bits outside the interrupt mask; an over-wide mask would raise sci_o from those bits. The timer rollover is timed to the cycle: sci_o must rise exactly when the counter reads 1.

// File: rtl/pm_sci_pkg.sv
// Shared constants for the power-management event block.
// Assumes a 16-bit I/O address space and 16-bit event registers.
package pm_sci_pkg;
    localparam int unsigned IO_AW = 16;
    localparam int unsigned REG_W = 16;

    // Register offsets inside the I/O window (software decodes these).
    localparam logic [5:0] OFS_STS = 6'h00;
    localparam logic [5:0] OFS_EN  = 6'h02;
    localparam logic [5:0] OFS_CTL = 6'h04;
    localparam logic [5:0] OFS_TMR = 6'h08;

    // Bit positions shared by status and enable.
    localparam int unsigned BIT_TMR    = 0;
    localparam int unsigned BIT_GBL    = 5;
    localparam int unsigned BIT_PWRBTN = 8;
    localparam int unsigned BIT_RTC    = 10;
    localparam int unsigned BIT_SCIEN  = 0;

    localparam logic [REG_W-1:0] SCI_MASK =
        REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));

    // Command bytes.
    localparam logic [7:0] CMD_ON  = 8'hF1;
    localparam logic [7:0] CMD_OFF = 8'hF0;

    // Configuration byte addresses.
    localparam logic [7:0] CFG_BASE0 = 8'h40;
    localparam logic [7:0] CFG_SMM0  = 8'h58;
    localparam logic [7:0] CFG_WINEN = 8'h80;
    localparam int unsigned CFG_GRP  = 4;
    localparam int unsigned SMI_ARM_BIT = 1;
endpackage

// File: rtl/pm_cfg_space.sv
// Byte-addressed configuration bytes for the block: base dword, the
// four SMM bytes and the window-enable byte. Derives the window base
// (aligned to the window size) and the decode enable.
// Assumes single-byte accesses; unmapped bytes read zero.
module pm_cfg_space
    import pm_sci_pkg::*;
#(
    parameter int unsigned WIN_BITS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output logic [IO_AW-1:0] win_base,
    output logic             win_en,
    output logic             smi_arm
);
    localparam logic [IO_AW-1:0] BASE_MASK = ~IO_AW'((1 << WIN_BITS) - 1);

    logic [7:0] base_b [CFG_GRP];
    logic [7:0] smm_b  [CFG_GRP];
    logic [7:0] wen_b;

    for (genvar i = 0; i < CFG_GRP; i++) begin : g_bytes
        // Base dword byte i: plain read/write storage.
        always_ff @(posedge clk) begin
            if (!rst_n)
                base_b[i] <= 8'h00;
            else if (cfg_wr && cfg_addr == CFG_BASE0 + 8'(i))
                base_b[i] <= cfg_wdata;
        end
        // SMM control byte i: cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                smm_b[i] <= 8'h00;
            else if (cfg_wr && cfg_addr == CFG_SMM0 + 8'(i))
                smm_b[i] <= cfg_wdata;
        end
    end

    // Window-enable byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wen_b <= 8'h00;
        else if (cfg_wr && cfg_addr == CFG_WINEN)
            wen_b <= cfg_wdata;
    end

    // Read mux; bit 0 of the base's low byte is hardwired to one.
    always_comb begin
        cfg_rdata = 8'h00;
        for (int i = 0; i < CFG_GRP; i++) begin
            if (cfg_addr == CFG_BASE0 + 8'(i))
                cfg_rdata = (i == 0) ? (base_b[i] | 8'h01) : base_b[i];
            if (cfg_addr == CFG_SMM0 + 8'(i))
                cfg_rdata = smm_b[i];
        end
        if (cfg_addr == CFG_WINEN)
            cfg_rdata = wen_b;
    end

    // Derived decode controls.
    always_comb begin
        win_base = {base_b[1], base_b[0]} & BASE_MASK;
        win_en   = wen_b[0];
        smi_arm  = smm_b[CFG_GRP-1][SMI_ARM_BIT];
    end
endmodule

// File: rtl/pm_evt_regs.sv
// Event status (write-one-to-clear), event enable, control and the
// free-running timer, plus the window read mux.
// Assumes acc_wr is already qualified by the window decode.
module pm_evt_regs
    import pm_sci_pkg::*;
#(
    parameter int unsigned WIN_BITS = 6,
    parameter int unsigned TMR_W    = 24,
    parameter int unsigned DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic [WIN_BITS-1:0] acc_ofs,
    input  logic [REG_W-1:0]    acc_wdata,
    input  logic                ev_pwrbtn,
    input  logic                ev_rtc,
    input  logic                ev_glbl,
    input  logic                cmd_wr,
    input  logic [7:0]          cmd_data,
    output logic [REG_W-1:0]    sts_q,
    output logic [REG_W-1:0]    en_q,
    output logic [REG_W-1:0]    ctl_q,
    output logic [DATA_W-1:0]   rd_data
);
    localparam logic [WIN_BITS-1:0] O_STS = WIN_BITS'(OFS_STS);
    localparam logic [WIN_BITS-1:0] O_EN  = WIN_BITS'(OFS_EN);
    localparam logic [WIN_BITS-1:0] O_CTL = WIN_BITS'(OFS_CTL);
    localparam logic [WIN_BITS-1:0] O_TMR = WIN_BITS'(OFS_TMR);

    logic [TMR_W-1:0] tmr_q;
    logic             tmr_wrap;
    logic [REG_W-1:0] sts_set, sts_clr, ctl_d;

    assign tmr_wrap = &tmr_q;

    // Free-running timer.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_q + 1'b1;
    end

    // Set and clear vectors for the status register.
    always_comb begin
        sts_set = '0;
        sts_set[BIT_PWRBTN] = ev_pwrbtn;
        sts_set[BIT_RTC]    = ev_rtc;
        sts_set[BIT_GBL]    = ev_glbl;
        sts_set[BIT_TMR]    = tmr_wrap;
        sts_clr = (acc_wr && acc_ofs == O_STS) ? acc_wdata : '0;
    end

    // Status: clear first, then set, so a new event survives its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    // Enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= '0;
        else if (acc_wr && acc_ofs == O_EN) en_q <= acc_wdata;
    end

    // Next control value: I/O write, then command override of SCI enable.
    always_comb begin
        ctl_d = ctl_q;
        if (acc_wr && acc_ofs == O_CTL)
            ctl_d = acc_wdata;
        if (cmd_wr && cmd_data == CMD_ON)
            ctl_d[BIT_SCIEN] = 1'b1;
        else if (cmd_wr && cmd_data == CMD_OFF)
            ctl_d[BIT_SCIEN] = 1'b0;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // Window read mux; unassigned offsets read zero.
    always_comb begin
        case (acc_ofs)
            O_STS:   rd_data = DATA_W'(sts_q);
            O_EN:    rd_data = DATA_W'(en_q);
            O_CTL:   rd_data = DATA_W'(ctl_q);
            O_TMR:   rd_data = DATA_W'(tmr_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pm_sci_gen.sv
// Registered interrupt outputs: SCI level from enabled status and the
// external hotplug event, SMI one-cycle pulse per armed command write.
// Assumes all inputs are synchronous to clk.
module pm_sci_gen
    import pm_sci_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] sts_q,
    input  logic [REG_W-1:0] en_q,
    input  logic             hp_sts,
    input  logic             hp_en,
    input  logic             cmd_wr,
    input  logic             smi_arm,
    output logic             sci_o,
    output logic             smi_o
);
    // SCI level register.
    always_ff @(posedge clk) begin
        if (!rst_n) sci_o <= 1'b0;
        else        sci_o <= (|(sts_q & en_q & SCI_MASK)) || (hp_sts && hp_en);
    end

    // SMI pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_o <= 1'b0;
        else        smi_o <= cmd_wr && smi_arm;
    end
endmodule

// File: rtl/pm_sci_ctrl.sv
// Top of the power-management event block: window decode over the
// configuration-supplied base, event registers and interrupt outputs.
// Assumes accesses are aligned to the register they target.
module pm_sci_ctrl
    import pm_sci_pkg::*;
#(
    parameter int unsigned WIN_BITS = 6,
    parameter int unsigned TMR_W    = 24,
    parameter int unsigned DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              io_wr,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_data,
    input  logic              ev_pwrbtn,
    input  logic              ev_rtc,
    input  logic              ev_glbl,
    input  logic              hp_sts,
    input  logic              hp_en,
    output logic              sci_o,
    output logic              smi_o
);
    localparam logic [IO_AW-1:0] ADDR_MASK = ~IO_AW'((1 << WIN_BITS) - 1);

    logic [IO_AW-1:0]    win_base;
    logic                win_en, smi_arm, hit, acc_wr;
    logic [WIN_BITS-1:0] acc_ofs;
    logic [REG_W-1:0]    sts_q, en_q, ctl_q;
    logic [DATA_W-1:0]   rd_data;

    pm_cfg_space #(.WIN_BITS(WIN_BITS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_base(win_base),
        .win_en(win_en), .smi_arm(smi_arm)
    );

    // Window hit and access qualification.
    always_comb begin
        hit      = win_en && ((io_addr & ADDR_MASK) == win_base);
        acc_wr   = io_wr && hit;
        acc_ofs  = io_addr[WIN_BITS-1:0];
        io_rdata = hit ? rd_data : '0;
    end

    pm_evt_regs #(.WIN_BITS(WIN_BITS), .TMR_W(TMR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_ofs(acc_ofs),
        .acc_wdata(io_wdata), .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc),
        .ev_glbl(ev_glbl), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q), .rd_data(rd_data)
    );

    pm_sci_gen u_gen (
        .clk(clk), .rst_n(rst_n), .sts_q(sts_q), .en_q(en_q),
        .hp_sts(hp_sts), .hp_en(hp_en), .cmd_wr(cmd_wr), .smi_arm(smi_arm),
        .sci_o(sci_o), .smi_o(smi_o)
    );
endmodule

// File: rtl/pm_sci_chk.sv
// Protocol checker for pm_sci_ctrl, attached by bind below.
module pm_sci_chk
    import pm_sci_pkg::*;
#(
    parameter int unsigned WIN_BITS = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                io_wr,
    input logic                win_en,
    input logic                acc_wr,
    input logic [WIN_BITS-1:0] acc_ofs,
    input logic                wr_pwr_bit,
    input logic                ev_pwrbtn,
    input logic                cmd_wr,
    input logic [7:0]          cmd_data,
    input logic                smi_arm,
    input logic                hp_sts,
    input logic                hp_en,
    input logic [REG_W-1:0]    sts_q,
    input logic [REG_W-1:0]    en_q,
    input logic                sci_en_bit,
    input logic                sci_o,
    input logic                smi_o
);
    localparam logic [WIN_BITS-1:0] O_STS = WIN_BITS'(OFS_STS);

    // R2: a write with the window off leaves the enable register alone.
    a_r2_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !win_en) |=> $stable(en_q));

    // R4: a latched power-button bit holds unless software clears it.
    a_r4_pwr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[BIT_PWRBTN] && !(acc_wr && acc_ofs == O_STS && wr_pwr_bit))
        |=> sts_q[BIT_PWRBTN]);

    // R5: writing one clears the bit when no new event arrives.
    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_ofs == O_STS && wr_pwr_bit && !ev_pwrbtn)
        |=> !sts_q[BIT_PWRBTN]);

    // R6: no enabled source means SCI low on the next cycle.
    a_r6_sci_low: assert property (@(posedge clk) disable iff (!rst_n)
        (((sts_q & en_q & SCI_MASK) == '0) && !(hp_sts && hp_en)) |=> !sci_o);

    // R6: hotplug pending and enabled raises SCI on the next cycle.
    a_r6_sci_hp: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_sts && hp_en) |=> sci_o);

    // R8: mode commands set or clear the SCI enable bit.
    a_r8_cmd_on: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data == CMD_ON) |=> sci_en_bit);
    a_r8_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data == CMD_OFF) |=> !sci_en_bit);

    // R9: SMI only follows a command write, never when unarmed.
    a_r9_smi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> $past(cmd_wr));
    a_r9_smi_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !smi_arm) |=> !smi_o);
endmodule

bind pm_sci_ctrl pm_sci_chk #(.WIN_BITS(WIN_BITS)) i_pm_sci_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .win_en(win_en),
    .acc_wr(acc_wr), .acc_ofs(acc_ofs),
    .wr_pwr_bit(io_wdata[pm_sci_pkg::BIT_PWRBTN]), .ev_pwrbtn(ev_pwrbtn),
    .cmd_wr(cmd_wr), .cmd_data(cmd_data), .smi_arm(smi_arm),
    .hp_sts(hp_sts), .hp_en(hp_en), .sts_q(sts_q), .en_q(en_q),
    .sci_en_bit(ctl_q[pm_sci_pkg::BIT_SCIEN]), .sci_o(sci_o), .smi_o(smi_o)
);

// File: tb/test_pm_sci_ctrl.sv
module test_pm_sci_ctrl;
    localparam int unsigned TMR_W  = 8;
    localparam int unsigned DATA_W = 32;
    localparam logic [15:0] BASE   = 16'h1240;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00, cfg_rdata;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000, io_wdata = 16'h0000;
    logic [DATA_W-1:0] io_rdata;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_data = 8'h00;
    logic        ev_pwrbtn = 1'b0, ev_rtc = 1'b0, ev_glbl = 1'b0;
    logic        hp_sts = 1'b0, hp_en = 1'b0;
    logic        sci_o, smi_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pm_sci_ctrl #(.TMR_W(TMR_W), .DATA_W(DATA_W)) i_pm_sci_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .ev_pwrbtn(ev_pwrbtn),
        .ev_rtc(ev_rtc), .ev_glbl(ev_glbl), .hp_sts(hp_sts), .hp_en(hp_en),
        .sci_o(sci_o), .smi_o(smi_o)
    );

    // Vector: {enable[15:0], events{pwr,rtc,glbl}, {hp_sts,hp_en}, sci, status[15:0]}
    localparam logic [37:0] VEC [0:9] = '{
        {16'h0100, 3'b100, 2'b00, 1'b1, 16'h0100},
        {16'h0000, 3'b100, 2'b00, 1'b0, 16'h0100},
        {16'h0400, 3'b010, 2'b00, 1'b1, 16'h0400},
        {16'h0020, 3'b001, 2'b00, 1'b1, 16'h0020},
        {16'h0100, 3'b010, 2'b00, 1'b0, 16'h0400},
        {16'hFADE, 3'b111, 2'b00, 1'b0, 16'h0520},
        {16'h0000, 3'b000, 2'b11, 1'b1, 16'h0000},
        {16'h0000, 3'b000, 2'b10, 1'b0, 16'h0000},
        {16'h0000, 3'b000, 2'b01, 1'b0, 16'h0000},
        {16'h0520, 3'b111, 2'b00, 1'b1, 16'h0520}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        io_addr = a;
        #1 d = io_rdata;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic cmd_send(input logic [7:0] c);
        @(negedge clk);
        cmd_data = c; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    // Watchdog.
    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, t0, t1;
        logic [7:0]  c;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check("R1 sci", 32'(sci_o), 0);
        check("R1 smi", 32'(smi_o), 0);
        cfg_read(8'h40, c); check("R1 cfg40", 32'(c), 32'h01);
        cfg_read(8'h5B, c); check("R1 cfg5B", 32'(c), 0);
        cfg_read(8'h58, c); check("R1 cfg58", 32'(c), 0);

        // R2: base with low bits set, window still off.
        cfg_write(8'h40, 8'h42);
        cfg_write(8'h41, 8'h12);
        io_write(BASE + 16'h2, 16'h0120);
        io_read(BASE + 16'h2, d); check("R2 off read", d, 0);
        cfg_write(8'h80, 8'h01);
        io_read(BASE + 16'h2, d); check("R2 off write ignored", d, 0);
        cfg_read(8'h40, c); check("R2 bit0 reads 1", 32'(c), 32'h43);
        io_write(16'h1202, 16'h0120);
        io_read(BASE + 16'h2, d); check("R2 below base ignored", d, 0);
        io_read(16'h1202, d); check("R2 below base reads 0", d, 0);

        // R3: offsets.
        io_write(BASE + 16'h2, 16'hA5A5);
        io_read(BASE + 16'h2, d); check("R3 enable", d, 32'hA5A5);
        io_write(BASE + 16'h4, 16'h1230);
        io_read(BASE + 16'h4, d); check("R3 control", d, 32'h1230);
        io_write(BASE + 16'h6, 16'hFFFF);
        io_read(BASE + 16'h6, d); check("R3 unused reads 0", d, 0);
        io_read(BASE + 16'h2, d); check("R3 unused write ignored", d, 32'hA5A5);

        // R4/R6/R10: vector table.
        for (int i = 0; i < 10; i++) begin
            hp_sts = 1'b0; hp_en = 1'b0;
            io_write(BASE + 16'h2, 16'h0000);
            io_write(BASE + 16'h0, 16'hFFFF);
            {hp_sts, hp_en} = VEC[i][18:17];
            io_write(BASE + 16'h2, VEC[i][37:22]);
            @(negedge clk);
            {ev_pwrbtn, ev_rtc, ev_glbl} = VEC[i][21:19];
            @(negedge clk);
            {ev_pwrbtn, ev_rtc, ev_glbl} = 3'b000;
            @(negedge clk);
            check($sformatf("R6 R10 vec%0d sci", i), 32'(sci_o), 32'(VEC[i][16]));
            io_read(BASE, d);
            check($sformatf("R4 vec%0d status", i), d & 32'hFFFE, 32'(VEC[i][15:0]));
        end
        hp_sts = 1'b0; hp_en = 1'b0;

        // R5: write-one-to-clear, including set-wins on collision.
        io_write(BASE, 16'h0100);
        io_read(BASE, d); check("R5 w1c", d & 32'hFFFE, 32'h0420);
        io_write(BASE, 16'h0000);
        io_read(BASE, d); check("R5 zero no effect", d & 32'hFFFE, 32'h0420);
        @(negedge clk);
        io_addr = BASE; io_wdata = 16'h0400; io_wr = 1'b1; ev_rtc = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; ev_rtc = 1'b0;
        io_read(BASE, d); check("R5 event wins", d & 32'hFFFE, 32'h0420);
        io_write(BASE, 16'hFFFE);
        @(negedge clk);
        check("R6 sci drops after clear", 32'(sci_o), 0);

        // R7: timer advance and rollover timing.
        io_read(BASE + 16'h8, t0);
        repeat (6) @(negedge clk);
        io_read(BASE + 16'h8, t1);
        check("R7 timer advance", (t1 - t0) & 32'hFF, 32'd7);
        io_write(BASE + 16'h2, 16'h0001);
        d = 0;
        for (int k = 0; k < 600 && d != 32'h10; k++) io_read(BASE + 16'h8, d);
        io_write(BASE, 16'hFFFF);
        @(negedge clk);
        check("R7 sci low after clear", 32'(sci_o), 0);
        io_addr = BASE + 16'h8;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (sci_o) break;
        end
        #1 check("R7 sci at rollover", 32'(sci_o), 1);
        check("R7 timer at sci", io_rdata, 32'd1);
        io_read(BASE, d); check("R7 status bit0", d & 32'h1, 1);
        io_write(BASE + 16'h2, 16'h0000);

        // R8: mode commands.
        cmd_send(8'hF1);
        io_read(BASE + 16'h4, d); check("R8 on", d, 32'h1231);
        cmd_send(8'h55);
        io_read(BASE + 16'h4, d); check("R8 other keeps", d, 32'h1231);
        cmd_send(8'hF0);
        io_read(BASE + 16'h4, d); check("R8 off", d, 32'h1230);
        @(negedge clk);
        io_addr = BASE + 16'h4; io_wdata = 16'h0000; io_wr = 1'b1;
        cmd_data = 8'hF1; cmd_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; cmd_wr = 1'b0;
        io_read(BASE + 16'h4, d); check("R8 command wins", d, 32'h0001);

        // R9: SMI pulse.
        cmd_send(8'h00);
        check("R9 unarmed", 32'(smi_o), 0);
        cfg_write(8'h5B, 8'h02);
        cfg_read(8'h5B, c); check("R9 cfg5B", 32'(c), 32'h02);
        cmd_send(8'h00);
        check("R9 pulse", 32'(smi_o), 1);
        @(negedge clk);
        check("R9 one cycle", 32'(smi_o), 0);

        // R1: reset in mid-run.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 rerst sci", 32'(sci_o), 0);
        cfg_read(8'h5B, c); check("R1 rerst cfg5B", 32'(c), 0);
        cfg_read(8'h80, c); check("R1 rerst cfg80", 32'(c), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule